// File: doc/BRIEF.md
# SD Host Command-Issue Inhibit Tracker

This block decides, cycle by cycle, whether an SD host controller may put a new command on the CMD line. It also decides whether that command may be one that occupies the DAT lines. The command sequencer presents each command as a one-cycle issue strobe tagged with the command's kind. The block either accepts the command, which raises the CMD inhibit, or rejects it and flags the rejection. Response strobes are tagged as answering either the main command or an auxiliary one (an automatic stop or an automatic block-count prefix). Only a main response releases the CMD inhibit, and that release raises a one-cycle command-complete pulse.

The DAT inhibit follows the line-activity and read-activity status levels. When it falls, the block raises a one-cycle transfer-complete pulse. A conflict error or a not-issued error freezes the CMD inhibit at 1, so that only the error-recovery reset releases it, and that release produces no command-complete pulse. When a command is accepted while an automatic stop is still owed, the block raises a pulse telling the sequencer to send the automatic stop first. All pins are plain control and status levels or strobes. There is no back-pressure: a strobe that cannot be taken is dropped and reported on `iss_rej`.

Kind encoding on `iss_kind`: 0 = CMD-line only, 1 = data transfer, 2 = busy-signalling (R1b/R5b), 3 = read/write with automatic stop, 4 = read/write with count prefix. Every value other than 0 counts as DAT-using.

Top module: `sdh_inhibit_top`

## Requirements
- R1: `dat_inh` equals `dat_act | rd_act` as sampled at the previous clock edge.
- R2: When `dat_inh` goes from 1 to 0, `tc_irq` is 1 for exactly the cycle in which `dat_inh` first reads 0.
- R3: An issue strobe with a nonzero (DAT-using) `iss_kind` is rejected while `dat_inh` is 1, and this includes kind 2 (busy-signalling).
- R4: A response strobe with `rsp_main`=1 while `cmd_inh` is 1 (and no error is latched) clears `cmd_inh` at that edge and raises `cc_irq` in the same cycle.
- R5: A response strobe with `rsp_main`=0 never clears `cmd_inh`.
- R6: `cc_irq` lasts exactly one cycle.
- R7: An issue strobe with kind 0 is accepted while `dat_inh` is 1, provided `cmd_inh` is 0.
- R8: `err_conflict` or `err_nis` while `cmd_inh` is 1 keeps `cmd_inh` at 1 and ignores later main responses, with no `cc_irq`, until `rec_rst`.
- R9: An accepted strobe sets `cmd_inh` at that edge. A strobe that is not accepted (because `cmd_inh` is 1, because R3 applies, or because `rec_rst` is high) drives `iss_rej` high for the next cycle.
- R10: After `rst_n` low, all outputs are 0. `rec_rst` clears `cmd_inh` at the next edge without `cc_irq`.
- R11: A command is owed an automatic stop from the main response of a kind-3 command until the next auxiliary response. A command accepted during that time raises `stop_first` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_stb | input | 1 | Command issue request strobe |
| iss_kind | input | 3 | Kind of the requested command (encoding above) |
| rsp_stb | input | 1 | Response received strobe |
| rsp_main | input | 1 | 1 = response answers the main command, 0 = auxiliary |
| err_conflict | input | 1 | Command conflict error strobe |
| err_nis | input | 1 | Command not issued because of automatic-stop error |
| rec_rst | input | 1 | Error-recovery reset of the CMD tracker |
| dat_act | input | 1 | DAT line active status level |
| rd_act | input | 1 | Read transfer active status level |
| cmd_inh | output | 1 | CMD inhibit |
| dat_inh | output | 1 | DAT inhibit |
| cc_irq | output | 1 | Command-complete pulse |
| tc_irq | output | 1 | Transfer-complete pulse |
| iss_rej | output | 1 | Issue strobe rejected (one cycle after it) |
| stop_first | output | 1 | Automatic stop must precede the command just accepted |

## Verification
The hardest state to reach is the one in which a command is accepted while an automatic stop is still owed. The stimulus builds it in order: it issues a kind-3 command, delivers its main response, holds DAT activity to model the transfer, issues a CMD-only command, and only then returns the auxiliary response. The last step also shows that this response leaves the new command's inhibit in place. A second hard-to-reach case is the error lock. The stimulus delivers a main response after each of the two error kinds and shows that nothing is released until the recovery reset.

// File: rtl/sdh_inh_pkg.sv
package sdh_inh_pkg;
  localparam int KIND_W = 3;
  localparam int NSRC   = 2;

  typedef enum logic [KIND_W-1:0] {
    K_NORM     = 3'd0,
    K_DAT      = 3'd1,
    K_BUSY     = 3'd2,
    K_RW_ASTOP = 3'd3,
    K_RW_APRE  = 3'd4
  } cmd_kind_e;

  // Any kind except the CMD-only one occupies the DAT lines.
  function automatic logic kind_uses_dat(input logic [KIND_W-1:0] k);
    return k != K_NORM;
  endfunction

  function automatic logic kind_has_astop(input logic [KIND_W-1:0] k);
    return k == K_RW_ASTOP;
  endfunction
endpackage

// File: rtl/sdh_dat_track.sv
module sdh_dat_track #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] busy_src,
  output logic            dat_inh,
  output logic            tc_irq
);
  logic any_busy;
  assign any_busy = |busy_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_inh <= 1'b0;
      tc_irq  <= 1'b0;
    end else begin
      dat_inh <= any_busy;
      tc_irq  <= dat_inh & ~any_busy;
    end
  end
endmodule

// File: rtl/sdh_issue_gate.sv
module sdh_issue_gate
  import sdh_inh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_stb,
  input  logic [KIND_W-1:0] iss_kind,
  input  logic              rec_rst,
  input  logic              cmd_inh,
  input  logic              dat_inh,
  output logic              iss_acc,
  output logic              iss_rej
);
  logic dat_ok;
  assign dat_ok  = ~kind_uses_dat(iss_kind) | ~dat_inh;
  assign iss_acc = iss_stb & ~rec_rst & ~cmd_inh & dat_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iss_rej <= 1'b0;
    else        iss_rej <= iss_stb & ~iss_acc;
  end
endmodule

// File: rtl/sdh_cmd_track.sv
module sdh_cmd_track
  import sdh_inh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_acc,
  input  logic [KIND_W-1:0] iss_kind,
  input  logic              rsp_stb,
  input  logic              rsp_main,
  input  logic              err_conflict,
  input  logic              err_nis,
  input  logic              rec_rst,
  output logic              cmd_inh,
  output logic              cc_irq,
  output logic              stop_first
);
  logic stuck;       // error latched: inhibit frozen
  logic astop_arm;   // current command will owe an automatic stop
  logic astop_owed;  // automatic stop outstanding, hidden from cmd_inh
  logic aux_rsp, main_rsp, err_any;

  assign aux_rsp  = rsp_stb & ~rsp_main;
  assign main_rsp = rsp_stb & rsp_main;
  assign err_any  = err_conflict | err_nis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_inh    <= 1'b0;
      cc_irq     <= 1'b0;
      stop_first <= 1'b0;
      stuck      <= 1'b0;
      astop_arm  <= 1'b0;
      astop_owed <= 1'b0;
    end else if (rec_rst) begin
      cmd_inh    <= 1'b0;
      cc_irq     <= 1'b0;
      stop_first <= 1'b0;
      stuck      <= 1'b0;
      astop_arm  <= 1'b0;
      astop_owed <= 1'b0;
    end else begin
      cc_irq     <= 1'b0;
      stop_first <= iss_acc & astop_owed & ~aux_rsp;
      if (aux_rsp) astop_owed <= 1'b0;
      if (iss_acc) begin
        cmd_inh   <= 1'b1;
        stuck     <= 1'b0;
        astop_arm <= kind_has_astop(iss_kind);
      end else if (cmd_inh) begin
        if (err_any) begin
          stuck <= 1'b1;
        end else if (main_rsp && !stuck) begin
          cmd_inh   <= 1'b0;
          cc_irq    <= 1'b1;
          astop_arm <= 1'b0;
          if (astop_arm) astop_owed <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdh_inhibit_top.sv
module sdh_inhibit_top
  import sdh_inh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_stb,
  input  logic [KIND_W-1:0] iss_kind,
  input  logic              rsp_stb,
  input  logic              rsp_main,
  input  logic              err_conflict,
  input  logic              err_nis,
  input  logic              rec_rst,
  input  logic              dat_act,
  input  logic              rd_act,
  output logic              cmd_inh,
  output logic              dat_inh,
  output logic              cc_irq,
  output logic              tc_irq,
  output logic              iss_rej,
  output logic              stop_first
);
  logic iss_acc;

  sdh_dat_track #(.NSRC(NSRC)) u_dat (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_src ({rd_act, dat_act}),
    .dat_inh  (dat_inh),
    .tc_irq   (tc_irq)
  );

  sdh_issue_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_stb  (iss_stb),
    .iss_kind (iss_kind),
    .rec_rst  (rec_rst),
    .cmd_inh  (cmd_inh),
    .dat_inh  (dat_inh),
    .iss_acc  (iss_acc),
    .iss_rej  (iss_rej)
  );

  sdh_cmd_track u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_acc      (iss_acc),
    .iss_kind     (iss_kind),
    .rsp_stb      (rsp_stb),
    .rsp_main     (rsp_main),
    .err_conflict (err_conflict),
    .err_nis      (err_nis),
    .rec_rst      (rec_rst),
    .cmd_inh      (cmd_inh),
    .cc_irq       (cc_irq),
    .stop_first   (stop_first)
  );
endmodule

// File: rtl/sdh_inhibit_chk.sv
module sdh_inhibit_chk
  import sdh_inh_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              iss_stb,
  input logic [KIND_W-1:0] iss_kind,
  input logic              rsp_stb,
  input logic              rsp_main,
  input logic              err_conflict,
  input logic              err_nis,
  input logic              rec_rst,
  input logic              dat_act,
  input logic              rd_act,
  input logic              cmd_inh,
  input logic              dat_inh,
  input logic              cc_irq,
  input logic              tc_irq,
  input logic              iss_rej
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r1_dat_or: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (dat_inh == $past(dat_act | rd_act)));

  a_r2_tc_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && tc_irq) |-> ($past(dat_inh) && !dat_inh));

  a_r3_dat_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_stb && iss_kind != K_NORM && dat_inh) |=> iss_rej);

  a_r4_cc_from_main: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cc_irq) |-> $past(rsp_stb && rsp_main && cmd_inh));

  a_r5_aux_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inh && rsp_stb && !rsp_main && !rec_rst) |=> cmd_inh);

  a_r6_cc_single: assert property (@(posedge clk) disable iff (!rst_n)
    cc_irq |=> !cc_irq);

  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inh && (err_conflict || err_nis) && !rec_rst) |=> (cmd_inh && !cc_irq));

  a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_stb && cmd_inh) |=> iss_rej);

  a_r10_recover: assert property (@(posedge clk) disable iff (!rst_n)
    rec_rst |=> (!cmd_inh && !cc_irq));
endmodule

bind sdh_inhibit_top sdh_inhibit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .iss_stb      (iss_stb),
  .iss_kind     (iss_kind),
  .rsp_stb      (rsp_stb),
  .rsp_main     (rsp_main),
  .err_conflict (err_conflict),
  .err_nis      (err_nis),
  .rec_rst      (rec_rst),
  .dat_act      (dat_act),
  .rd_act       (rd_act),
  .cmd_inh      (cmd_inh),
  .dat_inh      (dat_inh),
  .cc_irq       (cc_irq),
  .tc_irq       (tc_irq),
  .iss_rej      (iss_rej)
);

// File: tb/sdh_inhibit_top_tb.sv
module sdh_inhibit_top_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_stb = 1'b0, rsp_stb = 1'b0, rsp_main = 1'b0;
  logic [2:0] iss_kind = 3'd0;
  logic err_conflict = 1'b0, err_nis = 1'b0, rec_rst = 1'b0;
  logic dat_act = 1'b0, rd_act = 1'b0;
  logic cmd_inh, dat_inh, cc_irq, tc_irq, iss_rej, stop_first;

  int checks = 0;
  int errors = 0;
  logic [5:0] q_exp[$];
  string      q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  sdh_inhibit_top u_dut (
    .clk(clk), .rst_n(rst_n), .iss_stb(iss_stb), .iss_kind(iss_kind),
    .rsp_stb(rsp_stb), .rsp_main(rsp_main), .err_conflict(err_conflict),
    .err_nis(err_nis), .rec_rst(rec_rst), .dat_act(dat_act), .rd_act(rd_act),
    .cmd_inh(cmd_inh), .dat_inh(dat_inh), .cc_irq(cc_irq), .tc_irq(tc_irq),
    .iss_rej(iss_rej), .stop_first(stop_first)
  );

  // observed vector: {cmd_inh, dat_inh, cc_irq, tc_irq, iss_rej, stop_first}
  function automatic logic [5:0] obs_vec();
    return {cmd_inh, dat_inh, cc_irq, tc_irq, iss_rej, stop_first};
  endfunction

  // Monitor: compares outputs a quarter period after each rising edge.
  always @(posedge clk) begin
    logic [5:0] e;
    string t;
    #(CLK_P/4);
    if (q_exp.size() > 0) begin
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (obs_vec() !== e) begin
        errors++;
        $display("FAIL %s: got %b expected %b", t, obs_vec(), e);
      end
    end
  end

  // Driver: drives one cycle of inputs and queues the outputs expected after that edge.
  task automatic step(input logic stb, input logic [2:0] kind, input logic rsp,
                      input logic mn, input logic conf, input logic nis,
                      input logic rec, input logic da, input logic ra,
                      input logic [5:0] exp, input string tag);
    @(negedge clk);
    iss_stb = stb; iss_kind = kind; rsp_stb = rsp; rsp_main = mn;
    err_conflict = conf; err_nis = nis; rec_rst = rec;
    dat_act = da; rd_act = ra;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    checks++;
    if (obs_vec() !== 6'b0) begin
      errors++;
      $display("FAIL R10 reset: got %b expected %b", obs_vec(), 6'b0);
    end
    rst_n = 1'b1;
    //   stb kind rsp mn cf ns rc da ra  expected
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b000000, "R10 idle after reset");
    step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b100000, "R9 accept sets cmd_inh");
    step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b100010, "R9 reject while cmd_inh");
    step(0, 3'd0, 1, 1, 0, 0, 0, 0, 0, 6'b001000, "R4 main response clears");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b000000, "R6 cc one cycle");
    step(0, 3'd0, 0, 0, 0, 0, 0, 1, 0, 6'b010000, "R1 dat_act sets dat_inh");
    step(1, 3'd2, 0, 0, 0, 0, 0, 1, 0, 6'b010010, "R3 busy kind rejected");
    step(1, 3'd1, 0, 0, 0, 0, 0, 1, 0, 6'b010010, "R3 data kind rejected");
    step(1, 3'd0, 0, 0, 0, 0, 0, 1, 0, 6'b110000, "R7 cmd-only accepted");
    step(0, 3'd0, 1, 1, 0, 0, 0, 1, 0, 6'b011000, "R4 clear under dat_inh");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, 6'b010000, "R1 rd_act holds dat_inh");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b000100, "R2 tc on fall");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b000000, "R2 tc one cycle");
    step(1, 3'd4, 0, 0, 0, 0, 0, 0, 0, 6'b100000, "R9 prefix kind accepted");
    step(0, 3'd0, 1, 0, 0, 0, 0, 0, 0, 6'b100000, "R5 prefix aux keeps");
    step(0, 3'd0, 1, 1, 0, 0, 0, 0, 0, 6'b001000, "R5 main after prefix");
    step(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 6'b100000, "R9 auto-stop kind accepted");
    step(0, 3'd0, 1, 1, 0, 0, 0, 0, 0, 6'b001000, "R4 main of auto-stop cmd");
    step(0, 3'd0, 0, 0, 0, 0, 0, 1, 0, 6'b010000, "R1 transfer active");
    step(1, 3'd0, 0, 0, 0, 0, 0, 1, 0, 6'b110001, "R11 stop_first on accept");
    step(0, 3'd0, 1, 0, 0, 0, 0, 1, 0, 6'b110000, "R5 auto-stop aux keeps");
    step(0, 3'd0, 1, 1, 0, 0, 0, 0, 0, 6'b001100, "R4 R2 clear and tc");
    step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b100000, "R11 no stop owed");
    step(0, 3'd0, 0, 0, 1, 0, 0, 0, 0, 6'b100000, "R8 conflict holds");
    step(0, 3'd0, 1, 1, 0, 0, 0, 0, 0, 6'b100000, "R8 main ignored after conflict");
    step(0, 3'd0, 0, 0, 0, 0, 1, 0, 0, 6'b000000, "R10 recovery no cc");
    step(1, 3'd1, 0, 0, 0, 0, 0, 0, 0, 6'b100000, "R9 data kind accepted");
    step(0, 3'd0, 0, 0, 0, 1, 0, 0, 0, 6'b100000, "R8 not-issued holds");
    step(0, 3'd0, 1, 1, 0, 0, 0, 0, 0, 6'b100000, "R8 main ignored after nis");
    step(1, 3'd0, 0, 0, 0, 0, 1, 0, 0, 6'b000010, "R10 recovery rejects strobe");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 6'b000000, "R6 no cc after recovery");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule